// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between on-chip logic and an external asynchronous static RAM of 256K words by 16 bits with two byte lanes. A requester hands it one word access at a time: an address, a write flag, write data and a two-bit lane mask. The controller turns that into a strobe sequence for the memory: chip select, write strobe, output enable and two active-low lane enables. It also controls a data bus that is split into an output value, a drive enable and a sampled input. Reads return the captured word with a one-cycle valid pulse.

The numbers of clock cycles spent on the read access, the write pulse and the bus turnaround are not fixed. They are parameters computed from the clock period and the memory's nanosecond limits, each rounded up to whole cycles. With a 10 ns clock the read access takes 2 cycles, the write pulse 1 cycle and the turnaround 1 cycle. The controller never lets its own drivers overlap the memory's output drivers.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held low on a clock edge, the outputs become: `req_ready` = 1, `rsp_valid` = 0, all five memory strobes high (inactive), and `mem_dq_oe` = 0.
- R2: A write stores only the lanes whose mask bit is set. Mask bit 0 selects data bits 7:0 (`mem_lb_n` low), bit 1 selects bits 15:8 (`mem_ub_n` low). A mask of 2'b00 leaves the word unchanged.
- R3: A read returns the stored value in enabled lanes and zero in lanes whose mask bit is clear.
- R4: `rsp_valid` is high for exactly one cycle, in the cycle that follows READ_CYC clock edges after the accepting edge. READ_CYC is the access time of 12 ns divided by the clock period, rounded up.
- R5: A request is taken only while `req_ready` is high. `req_ready` is then low for READ_CYC+TURN_CYC cycles on a read and TURN_CYC+WRITE_CYC+1 cycles on a write.
- R6: `mem_dq_oe` is raised only when `mem_oe_n` has already been high for at least one cycle. The controller and the memory never drive the bus in the same cycle.
- R7: `mem_we_n` stays low for exactly WRITE_CYC cycles with `mem_ce_n` low. Address and write data are held steady throughout.
- R8: `mem_dq_oe` stays high in the first cycle after `mem_we_n` rises and is low in the cycle after that.
- R9: While `req_ready` is high, `mem_ce_n`, `mem_lb_n` and `mem_ub_n` are all high.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and `mem_oe_n` is low only during a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Sampled data bus |

## Verification
The assertions assume that the requester holds `req_valid` and its fields stable only in the cycle where they are sampled with `req_ready` high. They also assume that `mem_dq_in` carries the memory's value by the last access cycle. The bench drives requests at the falling edge, only after it has seen `req_ready` high, and drops `req_valid` after one accepting edge. Its memory model returns a junk pattern until the read strobes have been low for READ_CYC falling edges. It commits a write only when it sees `mem_we_n` rise with chip select low, so a short access or an early capture shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding, strobe bundle and cycle arithmetic for
// the asynchronous SRAM controller. Assumes integer nanosecond timings.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_WR_SETUP   = 3'd1,
        S_WR_STROBE  = 3'd2,
        S_WR_RELEASE = 3'd3,
        S_RD_ACCESS  = 3'd4,
        S_RD_RECOVER = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lb_n;
        logic ub_n;
        logic dq_oe;
    } strobe_t;

    // Whole cycles covering ns_val at clk_ns per cycle, never below one.
    function automatic int cycles_for(input int ns_val, input int clk_ns);
        int c;
        c = (ns_val + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Sequencer: accepts one request in idle, latches its fields and walks the
// read or write phase sequence with a down-counter per phase. Assumes the
// phase lengths are at least one cycle each.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int LANES    = 2,
    parameter int READ_CYC = 2,
    parameter int WRITE_CYC = 1,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output seq_state_e        state_o,
    output logic              rd_last_o,
    output logic [ADDR_W-1:0] lat_addr_o,
    output logic [DATA_W-1:0] lat_wdata_o,
    output logic [LANES-1:0]  lat_be_o
);
    localparam int MAX_CYC = max3(READ_CYC, WRITE_CYC, TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(READ_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;
    logic             accept;

    assign cnt_zero = (cnt_q == '0);
    assign accept   = (st_q == S_IDLE) && req_valid;

    // Next phase and counter reload for the running access.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    st_d  = req_write ? S_WR_SETUP : S_RD_ACCESS;
                    cnt_d = req_write ? TURN_LOAD : RD_LOAD;
                end
            end
            S_WR_SETUP: begin
                if (cnt_zero) begin
                    st_d  = S_WR_STROBE;
                    cnt_d = WR_LOAD;
                end
            end
            S_WR_STROBE: begin
                if (cnt_zero) st_d = S_WR_RELEASE;
            end
            S_WR_RELEASE: begin
                st_d = S_IDLE;
            end
            S_RD_ACCESS: begin
                if (cnt_zero) begin
                    st_d  = S_RD_RECOVER;
                    cnt_d = TURN_LOAD;
                end
            end
            S_RD_RECOVER: begin
                if (cnt_zero) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Request fields held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_o  <= '0;
            lat_wdata_o <= '0;
            lat_be_o    <= '0;
        end else if (accept) begin
            lat_addr_o  <= req_addr;
            lat_wdata_o <= req_wdata;
            lat_be_o    <= req_be;
        end
    end

    assign state_o   = st_q;
    assign rd_last_o = (st_q == S_RD_ACCESS) && cnt_zero;

    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q != S_IDLE)); // R5
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) && (st_d != S_IDLE) |=> $stable(lat_addr_o) && $stable(lat_be_o)); // R7
endmodule

// File: rtl/sram_strobe_decode.sv
// Strobe decoder: maps the sequencer phase and latched lane mask onto the
// active-low memory strobes and the data drive enable. Purely combinational;
// assumes the phase register is glitch-free at the clock edge.
module sram_strobe_decode
    import sram_ctrl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  seq_state_e       state_i,
    input  logic [LANES-1:0] be_i,
    output strobe_t          strb_o
);
    // Phase-to-strobe table; lanes follow the mask only inside an access.
    always_comb begin
        strb_o = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1, dq_oe: 1'b0};
        unique case (state_i)
            S_WR_SETUP: begin
                strb_o.ce_n = 1'b0;
                strb_o.lb_n = ~be_i[0];
                strb_o.ub_n = ~be_i[LANES-1];
            end
            S_WR_STROBE: begin
                strb_o.ce_n  = 1'b0;
                strb_o.we_n  = 1'b0;
                strb_o.lb_n  = ~be_i[0];
                strb_o.ub_n  = ~be_i[LANES-1];
                strb_o.dq_oe = 1'b1;
            end
            S_WR_RELEASE: begin
                strb_o.ce_n  = 1'b0;
                strb_o.lb_n  = ~be_i[0];
                strb_o.ub_n  = ~be_i[LANES-1];
                strb_o.dq_oe = 1'b1;
            end
            S_RD_ACCESS: begin
                strb_o.ce_n = 1'b0;
                strb_o.oe_n = 1'b0;
                strb_o.lb_n = ~be_i[0];
                strb_o.ub_n = ~be_i[LANES-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_read_capture.sv
// Read capture: registers the sampled bus on the last access cycle, zeroes
// disabled lanes and raises a one-cycle valid. Assumes 8-bit lanes.
module sram_read_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    // Per-lane zeroing of the sampled word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = be_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end

    // Capture register and single-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= capture_i;
            if (capture_i) data_o <= masked;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R4
endmodule

// File: rtl/sram_bus_ctrl.sv
// Top: synchronous front end for an external asynchronous SRAM with two byte
// lanes. Phase lengths come from the clock period and the memory's
// nanosecond limits. Assumes a single requester and one access at a time.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 16,
    parameter int LANES       = 2,
    parameter int CLK_NS      = 10,
    parameter int T_ACCESS_NS = 12,
    parameter int T_WPULSE_NS = 10,
    parameter int T_TURN_NS   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int READ_CYC  = cycles_for(T_ACCESS_NS, CLK_NS);
    localparam int WRITE_CYC = cycles_for(T_WPULSE_NS, CLK_NS);
    localparam int TURN_CYC  = cycles_for(T_TURN_NS, CLK_NS);

    seq_state_e        state;
    logic              rd_last;
    logic [LANES-1:0]  lat_be;
    strobe_t           strb;

    sram_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
        .READ_CYC(READ_CYC), .WRITE_CYC(WRITE_CYC), .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .state_o(state), .rd_last_o(rd_last),
        .lat_addr_o(mem_addr), .lat_wdata_o(mem_dq_out), .lat_be_o(lat_be)
    );

    sram_strobe_decode #(.LANES(LANES)) u_dec (
        .state_i(state), .be_i(lat_be), .strb_o(strb)
    );

    sram_read_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .capture_i(rd_last), .be_i(lat_be), .dq_i(mem_dq_in),
        .valid_o(rsp_valid), .data_o(rsp_rdata)
    );

    assign req_ready = (state == S_IDLE);
    assign mem_ce_n  = strb.ce_n;
    assign mem_we_n  = strb.we_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_lb_n  = strb.lb_n;
    assign mem_ub_n  = strb.ub_n;
    assign mem_dq_oe = strb.dq_oe;

    AST_DRIVE_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> mem_oe_n && $past(mem_oe_n)); // R6
    AST_RELEASE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe); // R8
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n && mem_oe_n); // R10
    AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n && !$past(mem_we_n) |-> $stable(mem_addr) && $stable(mem_dq_out)); // R7
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R5
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n && mem_lb_n && mem_ub_n); // R9
endmodule

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;
    localparam int CLK_NS = 10;
    localparam int RD_CYC = (12 + CLK_NS - 1) / CLK_NS;
    localparam int WR_CYC = (10 + CLK_NS - 1) / CLK_NS;
    localparam int TN_CYC = (6 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #10 clk = ~clk;

    sram_bus_ctrl u_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model and the bench's own expected contents.
    logic [15:0] smem [logic [17:0]];
    logic [15:0] shadow [logic [17:0]];
    int rd_age = 0;
    logic sram_drive;
    logic [15:0] sram_word;

    function automatic logic [15:0] look(input logic [17:0] a);
        return smem.exists(a) ? smem[a] : 16'h0000;
    endfunction

    assign sram_drive = !mem_ce_n && !mem_oe_n && mem_we_n && (!mem_lb_n || !mem_ub_n);
    assign sram_word  = (rd_age >= RD_CYC) ? look(mem_addr) : 16'hBAD0;
    assign mem_dq_in[7:0]  = (sram_drive && !mem_lb_n) ? sram_word[7:0]
                           : (mem_dq_oe ? mem_dq_out[7:0] : 8'h5A);
    assign mem_dq_in[15:8] = (sram_drive && !mem_ub_n) ? sram_word[15:8]
                           : (mem_dq_oe ? mem_dq_out[15:8] : 8'hA5);

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { logic [15:0] data; int at; } exp_t;
    exp_t sb[$];

    logic we_prev = 1'b1;
    bit   rel_pend = 0;
    int   we_len = 0;
    logic [17:0] we_addr;
    logic [15:0] we_data;

    // Monitor: memory model updates, protocol checks and scoreboard pops.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_drive) rd_age <= rd_age + 1; else rd_age <= 0;
            if (we_prev == 1'b0 && mem_we_n == 1'b1 && !mem_ce_n) begin
                logic [15:0] w;
                w = look(mem_addr);
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                smem[mem_addr] = w;
            end
            chk("R6 bus contention", {31'd0, mem_dq_oe && sram_drive}, 32'd0);
            chk("R10 oe/we overlap", {31'd0, !mem_oe_n && !mem_we_n}, 32'd0);
            if (req_ready) chk("R9 idle deselect", {29'd0, mem_ce_n, mem_lb_n, mem_ub_n}, 32'd7);
            if (!mem_we_n) begin
                chk("R7 ce during we", {31'd0, mem_ce_n}, 32'd0);
                if (we_len == 0) begin
                    we_addr = mem_addr;
                    we_data = mem_dq_out;
                end else begin
                    chk("R7 addr stable", {14'd0, mem_addr}, {14'd0, we_addr});
                    chk("R7 data stable", {16'd0, mem_dq_out}, {16'd0, we_data});
                end
                we_len++;
            end
            if (rel_pend) begin
                chk("R8 release", {31'd0, mem_dq_oe}, 32'd0);
                rel_pend = 0;
            end
            if (we_prev == 1'b0 && mem_we_n == 1'b1) begin
                chk("R7 pulse width", we_len, WR_CYC);
                chk("R8 hold after we", {31'd0, mem_dq_oe}, 32'd1);
                rel_pend = 1;
                we_len = 0;
            end
            we_prev = mem_we_n;
            if (rsp_valid) begin
                if (sb.size() == 0) chk("R4 spurious valid", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R3 read data", {16'd0, rsp_rdata}, {16'd0, e.data});
                    chk("R4 latency", cyc, e.at);
                end
            end
        end
    end

    // Driver: one access; expected read data goes to the scoreboard.
    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int busy;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        if (wr) begin
            logic [15:0] w;
            w = shadow.exists(a) ? shadow[a] : 16'h0000;
            if (be[0]) w[7:0]  = d[7:0];
            if (be[1]) w[15:8] = d[15:8];
            shadow[a] = w;
        end else begin
            exp_t e;
            e.data = (shadow.exists(a) ? shadow[a] : 16'h0000) & {{8{be[1]}}, {8{be[0]}}};
            e.at = cyc + 1 + RD_CYC;
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d;
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        chk("R5 busy length", busy, wr ? (TN_CYC + WR_CYC + 1) : (RD_CYC + TN_CYC));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 reset strobes", {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 32'h3E);
        chk("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // R2: full write then lane-only writes
        access(1, 18'd5, 16'h1234, 2'b11);
        access(0, 18'd5, 16'h0000, 2'b11);
        access(1, 18'd5, 16'hABCD, 2'b01);
        access(0, 18'd5, 16'h0000, 2'b11);
        access(1, 18'd5, 16'hEE77, 2'b10);
        access(0, 18'd5, 16'h0000, 2'b11);
        // R3: masked reads return zero in disabled lanes
        access(0, 18'd5, 16'h0000, 2'b01);
        access(0, 18'd5, 16'h0000, 2'b10);
        access(0, 18'd5, 16'h0000, 2'b00);
        // R2: empty mask writes nothing
        access(1, 18'd5, 16'h9999, 2'b00);
        access(0, 18'd5, 16'h0000, 2'b11);
        // address boundaries and alternating patterns
        access(1, 18'd0, 16'hFFFF, 2'b11);
        access(1, 18'h3FFFF, 16'h8001, 2'b11);
        access(0, 18'd0, 16'h0000, 2'b11);
        access(0, 18'h3FFFF, 16'h0000, 2'b11);
        for (int i = 0; i < 8; i++) begin
            access(1, 18'(i * 4099), 16'(16'h1111 * i + 16'h0F0F), 2'(i % 4));
            access(0, 18'(i * 4099), 16'h0000, 2'b11);
        end
        repeat (6) @(negedge clk);
        chk("R4 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule